// File: doc/BRIEF.md
# Planar Video Memory Access Unit

This block connects a byte-wide host memory port to a video memory stored as 32-bit words. Each word holds four 8-bit planes, and plane p occupies bits [8p+7:8p]. Every host byte access first passes a window decoder. It is then mapped to a word and a plane in one of three ways: linear (chain-4), interleaved (odd/even) or planar. Planar writes pass through a data pipeline with four write modes, a set/reset substitution, a rotator, a logic function and a bit mask. Planar reads load a 32-bit latch, and that latch feeds the write pipeline.

Writes finish in the cycle they are accepted and produce no response. Reads are handled by a small sequencer with three states: `ST_IDLE`, `ST_FETCH` and `ST_REPLY`. A read accepted in `ST_IDLE` or `ST_REPLY` moves the sequencer to `ST_FETCH`, and in that cycle the memory word is available. `ST_FETCH` always moves to `ST_REPLY`, which presents the response byte. `ST_REPLY` returns to `ST_IDLE`, or goes back to `ST_FETCH` if another read is accepted in it. Writes and idle cycles keep the sequencer in `ST_IDLE`.

Top module: `planar_vmem_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and the read latch holds zero. A write-mode-1 planar write issued before any read therefore stores 00h in every enabled plane.
- R2: `map_sel` selects the host window:
  - 0 selects A0000h–BFFFFh.
  - 1 selects A0000h–AFFFFh.
  - 2 selects B0000h–B7FFFh.
  - 3 selects B8000h–BFFFFh.

  The offset is the address minus the window base. A read outside the window returns FFh and leaves the latch unchanged. A write outside the window changes nothing.
- R3: With `chain4_en`=1, the word is offset>>2 and the plane is offset[1:0]. A read returns that plane's byte. A write stores `req_wdata` in that plane only.
- R4: With `chain4_en`=0 and `oddeven_en`=1, the plane is {`page_sel`, offset[0]} and the word is offset>>1. The access then behaves as in R3.
- R5: With both mapping enables at 0, the access is planar and the word is the offset. A planar read loads the whole word into the latch. With `read_mode`=0 it returns plane `read_plane`.
- R6: A planar read with `read_mode`=1 compares colours across the planes:
  - Each plane is XORed with a byte of all copies of `cmp_color[p]`.
  - The result is ANDed with all copies of `cmp_care[p]`.
  - The four resulting bytes are ORed together.
  - The read returns the bitwise inverse of that OR.
- R7: In write mode 0, the host byte is rotated right by `rot_cnt` and copied to all planes. A plane whose `sr_enable[p]` is 1 takes all copies of `sr_value[p]` instead.
- R8: In write mode 1, the latch is written unchanged. `fn_sel`, `bit_mask` and the host data are ignored.
- R9: In write mode 2, plane p takes all copies of `req_wdata[p]`.
- R10: In write mode 3, plane p takes all copies of `sr_value[p]`. The bit mask used is `bit_mask` AND the rotated host byte.
- R11: In write modes 0, 2 and 3, the data first passes the logic function, then the bit mask:
  - `fn_sel` 0 passes the data unchanged.
  - 1 ANDs it with the latch.
  - 2 ORs it with the latch.
  - 3 XORs it with the latch.

  Each bit then takes the function result where the mask is 1 and the latch bit where the mask is 0.
- R12: A planar write updates only the planes whose `map_mask` bit is set. A chain-4 or odd/even write is dropped if its plane's `map_mask` bit is 0.
- R13: A read accepted at clock edge E fills its response at edge E+1, so `rsp_valid` is high for the cycle after E+1. `req_ready` is low for the single cycle between E and E+1. Control inputs must stay steady through that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | HOST_AW | Host byte address |
| req_wdata | input | 8 | Host write byte |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 8 | Read response byte |
| map_sel | input | 2 | Host window select |
| chain4_en | input | 1 | Linear byte mapping |
| oddeven_en | input | 1 | Interleaved mapping |
| page_sel | input | 1 | High plane bit in interleaved mapping |
| map_mask | input | 4 | Per-plane write enable |
| write_mode | input | 2 | Planar write mode |
| rot_cnt | input | 3 | Right-rotate count |
| fn_sel | input | 2 | Logic function with latch |
| sr_value | input | 4 | Per-plane set/reset value |
| sr_enable | input | 4 | Per-plane set/reset enable |
| bit_mask | input | 8 | Bit mask selecting function result vs latch |
| read_mode | input | 1 | 0 = plane read, 1 = colour compare |
| read_plane | input | 2 | Plane returned in read mode 0 |
| cmp_color | input | 4 | Colour-compare value |
| cmp_care | input | 4 | Colour-compare care bits |

## Verification
The bench builds the block with HOST_AW=20 and WORD_AW=8, which gives a 256-word store. With that size, every window and every mapping folds onto words that the bench can preload in full. Aliasing then becomes observable. For example, a dropped out-of-window write can be confirmed by reading the word it would have hit through another window, and one cell can be reached from the linear, interleaved and planar mappings. Random runs over all write modes and functions then reach the latch-dependent paths with real data rather than uninitialised words.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
    localparam int PLANES = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = PLANES * LANE_W;

    typedef enum logic [1:0] {
        ACC_CHAIN4  = 2'd0,
        ACC_ODDEVEN = 2'd1,
        ACC_PLANAR  = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_REPLY = 2'd2
    } seq_state_e;

    // one bit per plane widened to a full lane of copies
    function automatic logic [WORD_W-1:0] spread_bits(input logic [PLANES-1:0] b);
        logic [WORD_W-1:0] r;
        for (int p = 0; p < PLANES; p++) begin
            r[p*LANE_W +: LANE_W] = {LANE_W{b[p]}};
        end
        return r;
    endfunction

    function automatic logic [LANE_W-1:0] rotate_right(input logic [LANE_W-1:0] v,
                                                       input logic [2:0] n);
        logic [2*LANE_W-1:0] t;
        t = {v, v} >> n;
        return t[LANE_W-1:0];
    endfunction
endpackage

// File: rtl/vmem_addr_map.sv
module vmem_addr_map
    import vmem_pkg::*;
#(
    parameter int HOST_AW = 20,
    parameter int WORD_AW = 10
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [1:0]         map_sel,
    input  logic               chain4_en,
    input  logic               oddeven_en,
    input  logic               page_sel,
    output logic               win_hit,
    output acc_kind_e          kind,
    output logic [WORD_AW-1:0] word_idx,
    output logic [1:0]         plane
);
    localparam int OFF_W = 17;

    logic [HOST_AW-1:0] base;
    logic [HOST_AW-1:0] span;
    logic [HOST_AW-1:0] off;
    logic [OFF_W-1:0]   offs;

    // window table: base and size per selector code
    always_comb begin
        unique case (map_sel)
            2'd0: begin base = HOST_AW'(20'hA0000); span = HOST_AW'(20'h20000); end
            2'd1: begin base = HOST_AW'(20'hA0000); span = HOST_AW'(20'h10000); end
            2'd2: begin base = HOST_AW'(20'hB0000); span = HOST_AW'(20'h08000); end
            default: begin base = HOST_AW'(20'hB8000); span = HOST_AW'(20'h08000); end
        endcase
    end

    assign off     = host_addr - base;
    assign win_hit = (host_addr >= base) && (off < span);
    assign offs    = OFF_W'(off);

    always_comb begin
        if (chain4_en) begin
            kind     = ACC_CHAIN4;
            plane    = offs[1:0];
            word_idx = WORD_AW'(offs >> 2);
        end else if (oddeven_en) begin
            kind     = ACC_ODDEVEN;
            plane    = {page_sel, offs[0]};
            word_idx = WORD_AW'(offs >> 1);
        end else begin
            kind     = ACC_PLANAR;
            plane    = 2'd0;
            word_idx = WORD_AW'(offs);
        end
    end
endmodule

// File: rtl/vmem_write_path.sv
module vmem_write_path
    import vmem_pkg::*;
(
    input  acc_kind_e           kind,
    input  logic [1:0]          plane,
    input  logic [PLANES-1:0]   map_mask,
    input  logic [LANE_W-1:0]   wdata,
    input  logic [1:0]          write_mode,
    input  logic [2:0]          rot_cnt,
    input  logic [1:0]          fn_sel,
    input  logic [PLANES-1:0]   sr_value,
    input  logic [PLANES-1:0]   sr_enable,
    input  logic [LANE_W-1:0]   bit_mask,
    input  logic [WORD_W-1:0]   latch,
    output logic [WORD_W-1:0]   wr_word,
    output logic [PLANES-1:0]   wr_be
);
    logic [LANE_W-1:0] rot_b;
    logic [LANE_W-1:0] eff_mask;
    logic [WORD_W-1:0] merged;

    assign rot_b    = rotate_right(wdata, rot_cnt);
    assign eff_mask = (write_mode == 2'd3) ? (bit_mask & rot_b) : bit_mask;

    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        logic [LANE_W-1:0] src;
        logic [LANE_W-1:0] alu;
        logic [LANE_W-1:0] lat;

        assign lat = latch[p*LANE_W +: LANE_W];

        always_comb begin
            unique case (write_mode)
                2'd0:    src = sr_enable[p] ? {LANE_W{sr_value[p]}} : rot_b;
                2'd2:    src = {LANE_W{wdata[p]}};
                default: src = {LANE_W{sr_value[p]}};
            endcase
        end

        always_comb begin
            unique case (fn_sel)
                2'd0:    alu = src;
                2'd1:    alu = src & lat;
                2'd2:    alu = src | lat;
                default: alu = src ^ lat;
            endcase
        end

        assign merged[p*LANE_W +: LANE_W] = (alu & eff_mask) | (lat & ~eff_mask);
    end

    always_comb begin
        if (kind != ACC_PLANAR) begin
            wr_word = {PLANES{wdata}};
            wr_be   = map_mask & (PLANES'(1) << plane);
        end else begin
            wr_word = (write_mode == 2'd1) ? latch : merged;
            wr_be   = map_mask;
        end
    end
endmodule

// File: rtl/vmem_read_path.sv
module vmem_read_path
    import vmem_pkg::*;
(
    input  acc_kind_e          kind,
    input  logic [1:0]         plane,
    input  logic               read_mode,
    input  logic [1:0]         read_plane,
    input  logic [PLANES-1:0]  cmp_color,
    input  logic [PLANES-1:0]  cmp_care,
    input  logic [WORD_W-1:0]  mem_q,
    output logic [LANE_W-1:0]  rd_byte
);
    logic [WORD_W-1:0] diff;
    logic [LANE_W-1:0] fold;
    logic [1:0]        sel;

    assign diff = (mem_q ^ spread_bits(cmp_color)) & spread_bits(cmp_care);

    always_comb begin
        fold = '0;
        for (int p = 0; p < PLANES; p++) begin
            fold = fold | diff[p*LANE_W +: LANE_W];
        end
    end

    assign sel = (kind == ACC_PLANAR) ? read_plane : plane;

    always_comb begin
        if (kind == ACC_PLANAR && read_mode) begin
            rd_byte = ~fold;
        end else begin
            rd_byte = mem_q[LANE_W*sel +: LANE_W];
        end
    end
endmodule

// File: rtl/vmem_store.sv
module vmem_store
    import vmem_pkg::*;
#(
    parameter int WORD_AW = 10
) (
    input  logic               clk,
    input  logic               we,
    input  logic [PLANES-1:0]  be,
    input  logic [WORD_AW-1:0] waddr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               re,
    input  logic [WORD_AW-1:0] raddr,
    output logic [WORD_W-1:0]  q
);
    localparam int DEPTH = 1 << WORD_AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int p = 0; p < PLANES; p++) begin
                if (be[p]) begin
                    mem[waddr][p*LANE_W +: LANE_W] <= wdata[p*LANE_W +: LANE_W];
                end
            end
        end
        if (re) begin
            q <= mem[raddr];
        end
    end
endmodule

// File: rtl/planar_vmem_unit.sv
module planar_vmem_unit
    import vmem_pkg::*;
#(
    parameter int HOST_AW = 20,
    parameter int WORD_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [HOST_AW-1:0] req_addr,
    input  logic [7:0]         req_wdata,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [7:0]         rsp_rdata,
    input  logic [1:0]         map_sel,
    input  logic               chain4_en,
    input  logic               oddeven_en,
    input  logic               page_sel,
    input  logic [3:0]         map_mask,
    input  logic [1:0]         write_mode,
    input  logic [2:0]         rot_cnt,
    input  logic [1:0]         fn_sel,
    input  logic [3:0]         sr_value,
    input  logic [3:0]         sr_enable,
    input  logic [7:0]         bit_mask,
    input  logic               read_mode,
    input  logic [1:0]         read_plane,
    input  logic [3:0]         cmp_color,
    input  logic [3:0]         cmp_care
);
    seq_state_e state_q, state_d;

    logic               win_hit;
    acc_kind_e          kind;
    logic [WORD_AW-1:0] word_idx;
    logic [1:0]         plane;

    logic               rd_go, wr_go;
    logic [WORD_W-1:0]  latch_q;
    logic [WORD_W-1:0]  mem_q;
    logic [WORD_W-1:0]  wr_word;
    logic [PLANES-1:0]  wr_be;
    logic [LANE_W-1:0]  rd_byte;
    logic [LANE_W-1:0]  rsp_rdata_q;

    acc_kind_e          rd_kind_q;
    logic [1:0]         rd_plane_q;
    logic               rd_hit_q;

    vmem_addr_map #(.HOST_AW(HOST_AW), .WORD_AW(WORD_AW)) i_map (
        .host_addr (req_addr),
        .map_sel   (map_sel),
        .chain4_en (chain4_en),
        .oddeven_en(oddeven_en),
        .page_sel  (page_sel),
        .win_hit   (win_hit),
        .kind      (kind),
        .word_idx  (word_idx),
        .plane     (plane)
    );

    vmem_write_path i_wpath (
        .kind      (kind),
        .plane     (plane),
        .map_mask  (map_mask),
        .wdata     (req_wdata),
        .write_mode(write_mode),
        .rot_cnt   (rot_cnt),
        .fn_sel    (fn_sel),
        .sr_value  (sr_value),
        .sr_enable (sr_enable),
        .bit_mask  (bit_mask),
        .latch     (latch_q),
        .wr_word   (wr_word),
        .wr_be     (wr_be)
    );

    vmem_store #(.WORD_AW(WORD_AW)) i_store (
        .clk  (clk),
        .we   (wr_go),
        .be   (wr_be),
        .waddr(word_idx),
        .wdata(wr_word),
        .re   (rd_go && win_hit),
        .raddr(word_idx),
        .q    (mem_q)
    );

    vmem_read_path i_rpath (
        .kind      (rd_kind_q),
        .plane     (rd_plane_q),
        .read_mode (read_mode),
        .read_plane(read_plane),
        .cmp_color (cmp_color),
        .cmp_care  (cmp_care),
        .mem_q     (mem_q),
        .rd_byte   (rd_byte)
    );

    // output process: handshake signals follow the state
    always_comb begin
        req_ready = (state_q != ST_FETCH);
        rsp_valid = (state_q == ST_REPLY);
        rsp_rdata = rsp_rdata_q;
    end

    assign rd_go = req_valid && req_ready && !req_write;
    assign wr_go = req_valid && req_ready && req_write && win_hit;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_REPLY: state_d = rd_go ? ST_FETCH : ST_IDLE;
            ST_FETCH:          state_d = ST_REPLY;
            default:           state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // read context, latch and response byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_kind_q   <= ACC_PLANAR;
            rd_plane_q  <= 2'd0;
            rd_hit_q    <= 1'b0;
            latch_q     <= '0;
            rsp_rdata_q <= '0;
        end else begin
            if (rd_go) begin
                rd_kind_q  <= kind;
                rd_plane_q <= plane;
                rd_hit_q   <= win_hit;
            end
            if (state_q == ST_FETCH) begin
                rsp_rdata_q <= rd_hit_q ? rd_byte : 8'hFF;
                if (rd_hit_q && rd_kind_q == ACC_PLANAR) begin
                    latch_q <= mem_q;
                end
            end
        end
    end

    AST_READ_REPLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> rsp_valid); // R13
    AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> !req_ready); // R13
    AST_OUTSIDE_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && !rd_hit_q) |=> (rsp_rdata == 8'hFF)); // R2
    AST_LANES_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> ((wr_be & ~map_mask) == 4'b0)); // R12
    AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && kind != ACC_PLANAR) |-> ($countones(wr_be) <= 1)); // R3
    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && kind == ACC_PLANAR && write_mode == 2'd1) |-> (wr_word == latch_q)); // R8
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FETCH) |=> $stable(latch_q)); // R5
endmodule

// File: tb/test_planar_vmem_unit.sv
`timescale 1ns/1ps
module test_planar_vmem_unit;
    localparam int HAW = 20;
    localparam int WAW = 8;
    localparam int DEPTH = 1 << WAW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [HAW-1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [7:0] rsp_rdata;
    logic [1:0] map_sel = 2'd0;
    logic chain4 = 1'b0, oddeven = 1'b0, page = 1'b0;
    logic [3:0] mmask = 4'hF;
    logic [1:0] wmode = 2'd0;
    logic [2:0] rot = 3'd0;
    logic [1:0] fsel = 2'd0;
    logic [3:0] srv = 4'h0, sre = 4'h0;
    logic [7:0] bmask = 8'hFF;
    logic rmode = 1'b0;
    logic [1:0] rplane = 2'd0;
    logic [3:0] ccmp = 4'h0, ccare = 4'h0;

    int total = 0;
    int bad = 0;

    logic [31:0] m_mem [DEPTH];
    logic [31:0] m_latch = '0;
    logic [7:0] exp_q [$];
    string tag_q [$];

    always #2.5 clk = ~clk;

    planar_vmem_unit #(.HOST_AW(HAW), .WORD_AW(WAW)) i_planar_vmem_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .map_sel(map_sel),
        .chain4_en(chain4), .oddeven_en(oddeven), .page_sel(page),
        .map_mask(mmask), .write_mode(wmode), .rot_cnt(rot), .fn_sel(fsel),
        .sr_value(srv), .sr_enable(sre), .bit_mask(bmask), .read_mode(rmode),
        .read_plane(rplane), .cmp_color(ccmp), .cmp_care(ccare)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] spread4(input logic [3:0] b);
        logic [31:0] r;
        for (int p = 0; p < 4; p++) r[8*p +: 8] = {8{b[p]}};
        return r;
    endfunction

    function automatic logic [7:0] ror8(input logic [7:0] v, input logic [2:0] n);
        logic [15:0] t;
        t = {v, v} >> n;
        return t[7:0];
    endfunction

    // reference mapping taken from R2, R3, R4, R5
    function automatic logic m_map(input logic [19:0] a, output int w, output int p, output int k);
        int base, span, off;
        case (map_sel)
            2'd0: begin base = 'hA0000; span = 'h20000; end
            2'd1: begin base = 'hA0000; span = 'h10000; end
            2'd2: begin base = 'hB0000; span = 'h8000; end
            default: begin base = 'hB8000; span = 'h8000; end
        endcase
        w = 0; p = 0; k = 2;
        if (int'(a) < base || int'(a) - base >= span) return 1'b0;
        off = int'(a) - base;
        if (chain4) begin k = 0; w = off >> 2; p = off & 3; end
        else if (oddeven) begin k = 1; p = (int'(page) << 1) | (off & 1); w = off >> 1; end
        else begin k = 2; w = off; p = 0; end
        w = w % DEPTH;
        return 1'b1;
    endfunction

    function automatic logic [7:0] m_read(input logic [19:0] a);
        int w, p, k;
        logic [31:0] d;
        if (!m_map(a, w, p, k)) return 8'hFF;
        if (k != 2) return m_mem[w][8*p +: 8];
        m_latch = m_mem[w];
        if (!rmode) return m_latch[8*rplane +: 8];
        d = (m_latch ^ spread4(ccmp)) & spread4(ccare);
        return ~(d[7:0] | d[15:8] | d[23:16] | d[31:24]);
    endfunction

    function automatic void m_write(input logic [19:0] a, input logic [7:0] v);
        int w, p, k;
        logic [31:0] src, alu, bm, res;
        logic [7:0] r;
        if (!m_map(a, w, p, k)) return;
        if (k != 2) begin
            if (mmask[p]) m_mem[w][8*p +: 8] = v;
            return;
        end
        r = ror8(v, rot);
        bm = {4{bmask}};
        case (wmode)
            2'd0: begin
                src = {4{r}};
                for (int q = 0; q < 4; q++) if (sre[q]) src[8*q +: 8] = {8{srv[q]}};
            end
            2'd2: src = spread4(v[3:0]);
            default: begin src = spread4(srv); bm = {4{bmask & r}}; end
        endcase
        case (fsel)
            2'd0: alu = src;
            2'd1: alu = src & m_latch;
            2'd2: alu = src | m_latch;
            default: alu = src ^ m_latch;
        endcase
        res = (wmode == 2'd1) ? m_latch : ((alu & bm) | (m_latch & ~bm));
        for (int q = 0; q < 4; q++) if (mmask[q]) m_mem[w][8*q +: 8] = res[8*q +: 8];
    endfunction

    task automatic host_write(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        m_write(a, d);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic host_read(input logic [19:0] a, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(m_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready && !rsp_valid, "R13 fetch cycle busy", {req_ready, rsp_valid}, 0);
        @(negedge clk);
        check(rsp_valid, "R13 reply cycle", rsp_valid, 1);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R13 unexpected response", rsp_rdata, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    task automatic planar_mode();
        chain4 = 1'b0; oddeven = 1'b0;
    endtask

    task automatic read_planes(input logic [19:0] a, input string tag);
        rmode = 1'b0;
        for (int p = 0; p < 4; p++) begin
            rplane = 2'(p);
            host_read(a, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R13 watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
        check(rsp_valid === 1'b0, "R1 no response after reset", rsp_valid, 0);
        // R1: latch is zero, so a write-mode-1 write clears the word
        planar_mode(); wmode = 2'd1; mmask = 4'hF;
        host_write(20'hA0005, 8'hAB);
        read_planes(20'hA0005, "R1 latch zero after reset");

        // preload every word
        wmode = 2'd0; fsel = 2'd0; sre = 4'h0; rot = 3'd0; bmask = 8'hFF;
        for (int w = 0; w < DEPTH; w++) host_write(20'hA0000 + 20'(w), 8'(w * 7 + 3));

        // R3 linear mapping
        chain4 = 1'b1; mmask = 4'hF;
        for (int i = 0; i < 8; i++) host_write(20'hA0010 + 20'(i), 8'(8'h31 + 8'(i * 17)));
        for (int i = 0; i < 8; i++) host_read(20'hA0010 + 20'(i), "R3 linear readback");
        // R12 map mask gates linear writes
        mmask = 4'b0101;
        host_write(20'hA0011, 8'hEE);
        host_write(20'hA0012, 8'h5A);
        host_read(20'hA0011, "R12 masked plane untouched");
        host_read(20'hA0012, "R12 enabled plane written");
        mmask = 4'hF;

        // R4 interleaved mapping
        chain4 = 1'b0; oddeven = 1'b1;
        page = 1'b0; host_write(20'hA0028, 8'h11); host_write(20'hA0029, 8'h22);
        page = 1'b1; host_write(20'hA0028, 8'h33); host_write(20'hA0029, 8'h44);
        page = 1'b0; host_read(20'hA0028, "R4 page0 even"); host_read(20'hA0029, "R4 page0 odd");
        page = 1'b1; host_read(20'hA0028, "R4 page1 even"); host_read(20'hA0029, "R4 page1 odd");
        oddeven = 1'b0; chain4 = 1'b1;
        host_read(20'hA0053, "R4 seen via linear map");

        // R5 planar plane reads
        planar_mode();
        read_planes(20'hA0004, "R5 plane read");
        read_planes(20'hA0014, "R5 plane read");

        // R6 colour compare
        rmode = 1'b1;
        ccmp = 4'hF; ccare = 4'hF; host_read(20'hA0020, "R6 compare all ones");
        ccmp = 4'h0; ccare = 4'hF; host_read(20'hA0021, "R6 compare zero");
        ccmp = 4'h5; ccare = 4'hA; host_read(20'hA0022, "R6 partial care");
        ccmp = 4'h3; ccare = 4'h0; host_read(20'hA0023, "R6 no care gives FF");
        rmode = 1'b0;

        // R7 write mode 0 with rotate and set/reset
        host_read(20'hA001E, "R5 latch load");
        wmode = 2'd0; rot = 3'd3; sre = 4'b0101; srv = 4'b0100; fsel = 2'd0; bmask = 8'hFF;
        host_write(20'hA001F, 8'hC5);
        read_planes(20'hA001F, "R7 rotate and set/reset");
        sre = 4'h0;

        // R11 functions and bit mask against the latch
        for (int f = 1; f < 4; f++) begin
            rmode = 1'b0; rplane = 2'd0;
            host_read(20'hA0030 + 20'(f), "R5 latch load");
            fsel = 2'(f); bmask = 8'h3C; rot = 3'd0; wmode = 2'd0;
            host_write(20'hA0040 + 20'(f), 8'h96);
            read_planes(20'hA0040 + 20'(f), "R11 function and mask");
        end

        // R8 write mode 1 copies latch, ignoring function, mask and data
        host_read(20'hA0032, "R5 latch load");
        wmode = 2'd1; fsel = 2'd3; bmask = 8'h00;
        host_write(20'hA0051, 8'hFF);
        read_planes(20'hA0051, "R8 latch copy");

        // R9 write mode 2
        host_read(20'hA0060, "R5 latch load");
        wmode = 2'd2; fsel = 2'd0; bmask = 8'hF0;
        host_write(20'hA0061, 8'h7A);
        read_planes(20'hA0061, "R9 expanded nibble");

        // R10 write mode 3
        wmode = 2'd3; rot = 3'd1; srv = 4'b1001; bmask = 8'h7E;
        host_write(20'hA0062, 8'hB3);
        read_planes(20'hA0062, "R10 rotated mask");

        // R12 planar map mask
        wmode = 2'd2; bmask = 8'hFF; mmask = 4'b0110;
        host_write(20'hA0063, 8'h0F);
        read_planes(20'hA0063, "R12 planar plane enable");
        mmask = 4'hF;

        // R2 window decode
        rmode = 1'b0; rplane = 2'd1;
        map_sel = 2'd1; host_read(20'hB0000, "R2 above 64K window");
        map_sel = 2'd2; host_read(20'hA0000, "R2 below window base");
        host_read(20'hB8000, "R2 above 32K window");
        map_sel = 2'd3; host_read(20'hC0000, "R2 past top window");
        map_sel = 2'd0; host_read(20'h9FFFF, "R2 below A0000");
        map_sel = 2'd1; wmode = 2'd2; host_write(20'hB0000, 8'h00);
        map_sel = 2'd0; host_read(20'hB0000, "R2 dropped write");
        map_sel = 2'd3; host_read(20'hB8003, "R2 window offset");
        map_sel = 2'd2; host_read(20'hB0005, "R2 window offset");
        map_sel = 2'd0;

        // mixed traffic
        for (int i = 0; i < 300; i++) begin
            logic [19:0] a;
            int kind;
            a = 20'hA0000 + 20'($urandom_range(0, 1023));
            kind = $urandom_range(0, 3);
            chain4 = (kind == 0); oddeven = (kind == 1); page = 1'($urandom);
            wmode = 2'($urandom); rot = 3'($urandom); fsel = 2'($urandom);
            srv = 4'($urandom); sre = 4'($urandom); bmask = 8'($urandom);
            mmask = 4'($urandom); rmode = 1'($urandom); rplane = 2'($urandom);
            ccmp = 4'($urandom); ccare = 4'($urandom);
            if ($urandom_range(0, 1) == 0) host_write(a, 8'($urandom));
            else if (kind == 0) host_read(a, "R3 mixed");
            else if (kind == 1) host_read(a, "R4 mixed");
            else if (rmode) host_read(a, "R6 mixed");
            else host_read(a, "R11 mixed");
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R13 all responses seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule